// File: doc/BRIEF.md
# Fixed-Point to Single-Precision Float Converter

This block turns a 32-bit signed fixed-point word into an IEEE-754 single-precision word. The binary point is not fixed. A 5-bit run-time input gives the number of fractional bits, from 0 to 31. The block first takes the absolute value of the word and finds its most significant set bit. The exponent is that bit's index minus the fractional-bit count, plus the bias of 127. The bits below the leading one are left-aligned into the 23-bit fraction field.

The conversion is purely combinational, so a new result appears in the same cycle as its inputs. The clock and reset ports exist only so the block fits a clocked pipeline. They do not touch the datapath. When the word has more significant bits than the fraction field can hold, the excess low bits are dropped without rounding. Infinities, NaNs and denormal results cannot arise from a 32-bit input, and the block does not produce them.

Top module: `fx2fp_convert`

## Requirements
- R1: An all-zero fixed-point word gives the all-zero float word (sign 0, exponent field 0, fraction 0), whatever the fractional-bit count.
- R2: The float sign (bit 31) equals bit 31 of a nonzero input. A negative input is converted through its two's-complement magnitude, so a value and its negation differ only in bit 31 of the result.
- R3: For a nonzero input whose magnitude has its highest set bit at index p, the exponent field (bits 30..23) equals 127 + p − f, where f is the fractional-bit count.
- R4: The fraction field (bits 22..0) holds the magnitude bits below the leading one, most significant first, padded with zeros on the right. When the magnitude has 24 or fewer significant bits, the result equals the value exactly.
- R5: When the magnitude has more than 24 significant bits, the bits below the 23 kept fraction bits are discarded by truncation (0x7FFFFFFF with f = 0 gives 0x4EFFFFFF).
- R6: The most negative input 0x80000000 is taken as magnitude 2^31; with f = 0 it gives 0xCF000000.
- R7: 0x00000420 with f = 7 gives 0x41040000 (8.25); 0x00000065 with f = 2 gives 0x41CA0000 (25.25).
- R8: The output depends only on the current data inputs, within the same cycle, and is unaffected by the clock and by reset being asserted.
- R9: The largest fractional-bit count is supported: input 0x00000001 with f = 31 gives 0x30000000 (2^−31, exponent field 96).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; does not affect the datapath |
| rst | input | 1 | Active-high reset; does not affect the datapath |
| fixed_word | input | 32 | Two's-complement fixed-point value |
| frac_bits | input | 5 | Number of bits right of the binary point |
| float_word | output | 32 | Single-precision result: sign, 8-bit biased exponent, 23-bit fraction |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between the inputs and `float_word`. The bench applies each input pair just after a falling clock edge and samples the output one time unit later, well before the next rising edge. Expected words come from a bench model that scans the magnitude from the low end and builds the fields bit by bit. The reset-time checks drive inputs while reset is high, to show that the output does not wait for reset to drop.

// File: rtl/fx2fp_pkg.sv
package fx2fp_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned FCNT_W  = 5;
  localparam int unsigned EXP_W   = 8;
  localparam int unsigned MAN_W   = 23;
  localparam int unsigned EXP_BIAS = 127;
  localparam int unsigned IDX_W   = $clog2(WORD_W);

  // Two's-complement absolute value; the most negative word maps to 2^(W-1).
  function automatic logic [WORD_W-1:0] abs_word(input logic [WORD_W-1:0] w);
    return w[WORD_W-1] ? (~w + WORD_W'(1)) : w;
  endfunction

  // Biased exponent from leading-one index and fractional-bit count.
  function automatic logic [EXP_W-1:0] biased_exp(input logic [IDX_W-1:0] lead,
                                                  input logic [FCNT_W-1:0] fcnt);
    int e;
    e = int'(EXP_BIAS) + int'(lead) - int'(fcnt);
    return EXP_W'(e);
  endfunction
endpackage

// File: rtl/fx2fp_magnitude.sv
module fx2fp_magnitude #(
  parameter int unsigned WORD_W = fx2fp_pkg::WORD_W
) (
  input  logic [WORD_W-1:0] word_in,
  output logic              neg_out,
  output logic              zero_out,
  output logic [WORD_W-1:0] mag_out
);
  assign neg_out  = word_in[WORD_W-1];
  assign zero_out = ~|word_in;
  assign mag_out  = neg_out ? (~word_in + WORD_W'(1)) : word_in;
endmodule

// File: rtl/fx2fp_lead_one.sv
module fx2fp_lead_one #(
  parameter int unsigned WORD_W = fx2fp_pkg::WORD_W,
  localparam int unsigned IDX_W = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] mag_in,
  output logic [IDX_W-1:0]  lead_idx
);
  logic [WORD_W-1:0] above;
  logic [WORD_W-1:0] onehot;

  // above[i] is set when any bit higher than i is set.
  assign above[WORD_W-1] = 1'b0;
  genvar gi;
  generate
    for (gi = WORD_W - 2; gi >= 0; gi--) begin : g_above
      assign above[gi] = above[gi+1] | mag_in[gi+1];
    end
  endgenerate

  assign onehot = mag_in & ~above;

  always_comb begin
    lead_idx = '0;
    for (int i = 0; i < int'(WORD_W); i++) begin
      if (onehot[i]) lead_idx = lead_idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/fx2fp_pack.sv
module fx2fp_pack #(
  parameter int unsigned WORD_W = fx2fp_pkg::WORD_W,
  parameter int unsigned FCNT_W = fx2fp_pkg::FCNT_W,
  parameter int unsigned EXP_W  = fx2fp_pkg::EXP_W,
  parameter int unsigned MAN_W  = fx2fp_pkg::MAN_W,
  localparam int unsigned IDX_W = $clog2(WORD_W),
  localparam int unsigned LOW_W = WORD_W - 1 - MAN_W
) (
  input  logic [WORD_W-1:0] mag_in,
  input  logic [IDX_W-1:0]  lead_idx,
  input  logic [FCNT_W-1:0] fcnt_in,
  output logic [EXP_W-1:0]  exp_out,
  output logic [MAN_W-1:0]  frac_out,
  output logic              hidden_bit,
  output logic              dropped_any
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WORD_W - 1);

  logic [IDX_W-1:0]  shift_amt;
  logic [WORD_W-1:0] norm;

  assign shift_amt   = TOP_IDX - lead_idx;
  assign norm        = mag_in << shift_amt;
  assign hidden_bit  = norm[WORD_W-1];
  assign frac_out    = norm[WORD_W-2 -: MAN_W];
  assign dropped_any = |norm[LOW_W-1:0];
  assign exp_out     = fx2fp_pkg::biased_exp(lead_idx, fcnt_in);
endmodule

// File: rtl/fx2fp_convert.sv
module fx2fp_convert #(
  parameter int unsigned WORD_W = fx2fp_pkg::WORD_W,
  parameter int unsigned FCNT_W = fx2fp_pkg::FCNT_W,
  parameter int unsigned EXP_W  = fx2fp_pkg::EXP_W,
  parameter int unsigned MAN_W  = fx2fp_pkg::MAN_W,
  localparam int unsigned IDX_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] fixed_word,
  input  logic [FCNT_W-1:0] frac_bits,
  output logic [WORD_W-1:0] float_word
);
  logic              in_neg;
  logic              in_zero;
  logic [WORD_W-1:0] mag;
  logic [IDX_W-1:0]  lead_idx;
  logic [EXP_W-1:0]  exp_field;
  logic [MAN_W-1:0]  frac_field;
  logic              hidden_bit;
  logic              dropped_any;

  fx2fp_magnitude #(.WORD_W(WORD_W)) mag_i (
    .word_in (fixed_word),
    .neg_out (in_neg),
    .zero_out(in_zero),
    .mag_out (mag)
  );

  fx2fp_lead_one #(.WORD_W(WORD_W)) lead_i (
    .mag_in  (mag),
    .lead_idx(lead_idx)
  );

  fx2fp_pack #(
    .WORD_W(WORD_W), .FCNT_W(FCNT_W), .EXP_W(EXP_W), .MAN_W(MAN_W)
  ) pack_i (
    .mag_in     (mag),
    .lead_idx   (lead_idx),
    .fcnt_in    (frac_bits),
    .exp_out    (exp_field),
    .frac_out   (frac_field),
    .hidden_bit (hidden_bit),
    .dropped_any(dropped_any)
  );

  assign float_word = in_zero ? '0 : {in_neg, exp_field, frac_field};
endmodule

// File: rtl/fx2fp_convert_chk.sv
module fx2fp_convert_chk #(
  parameter int unsigned WORD_W = fx2fp_pkg::WORD_W,
  parameter int unsigned FCNT_W = fx2fp_pkg::FCNT_W,
  parameter int unsigned MAN_W  = fx2fp_pkg::MAN_W,
  localparam int unsigned IDX_W = $clog2(WORD_W)
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] fixed_word,
  input logic [FCNT_W-1:0] frac_bits,
  input logic [WORD_W-1:0] float_word,
  input logic [WORD_W-1:0] mag,
  input logic [IDX_W-1:0]  lead_idx,
  input logic              hidden_bit,
  input logic              dropped_any
);
  // R1
  zero_in_zero_out_chk: assert property (@(posedge clk) disable iff (rst)
    (fixed_word == '0) |-> (float_word == '0));

  // R2
  sign_follows_input_chk: assert property (@(posedge clk) disable iff (rst)
    (fixed_word != '0) |-> (float_word[WORD_W-1] == fixed_word[WORD_W-1]));

  // R3
  lead_one_is_top_chk: assert property (@(posedge clk) disable iff (rst)
    (mag != '0) |-> ((mag >> lead_idx) == WORD_W'(1)));

  // R3
  exponent_field_chk: assert property (@(posedge clk) disable iff (rst)
    (fixed_word != '0) |->
      (float_word[WORD_W-2 -: 8] == fx2fp_pkg::biased_exp(lead_idx, frac_bits)));

  // R4
  hidden_one_set_chk: assert property (@(posedge clk) disable iff (rst)
    (mag != '0) |-> hidden_bit);

  // R4
  exact_small_chk: assert property (@(posedge clk) disable iff (rst)
    ((fixed_word != '0) && (int'(lead_idx) <= int'(MAN_W))) |->
      (((WORD_W'(1) << MAN_W) | WORD_W'(float_word[MAN_W-1:0]))
         >> (IDX_W'(MAN_W) - lead_idx)) == mag);

  // R5
  drop_only_when_wide_chk: assert property (@(posedge clk) disable iff (rst)
    dropped_any |-> (int'(lead_idx) > int'(MAN_W)));
endmodule

bind fx2fp_convert fx2fp_convert_chk #(
  .WORD_W(WORD_W), .FCNT_W(FCNT_W), .MAN_W(MAN_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .fixed_word (fixed_word),
  .frac_bits  (frac_bits),
  .float_word (float_word),
  .mag        (mag),
  .lead_idx   (lead_idx),
  .hidden_bit (hidden_bit),
  .dropped_any(dropped_any)
);

// File: tb/fx2fp_convert_tb_top.sv
module fx2fp_convert_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fixed_word = '0;
  logic [4:0]  frac_bits = '0;
  logic [31:0] float_word;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fx2fp_convert dut_i (
    .clk(clk), .rst(rst), .fixed_word(fixed_word),
    .frac_bits(frac_bits), .float_word(float_word)
  );

  // Independent model: upward scan for the top set bit, fields built bit by bit.
  function automatic logic [31:0] model(input logic [31:0] w, input logic [4:0] f);
    logic [31:0] m;
    logic [22:0] fr;
    int p;
    int e;
    if (w == 32'd0) return 32'd0;
    m = w[31] ? (32'd0 - w) : w;
    p = 0;
    for (int i = 0; i < 32; i++) if (m[i]) p = i;
    e = 127 + p - int'(f);
    fr = '0;
    for (int k = 1; k <= 23; k++) if (p - k >= 0) fr[23-k] = m[p-k];
    return {w[31], e[7:0], fr};
  endfunction

  task automatic check(input string req, input logic [31:0] w, input logic [4:0] f,
                       input logic [31:0] exp_val);
    @(negedge clk);
    fixed_word = w;
    frac_bits  = f;
    #1;
    checks++;
    if (float_word !== exp_val) begin
      errors++;
      $display("FAIL %s in=%h f=%0d actual=%h expected=%h", req, w, f, float_word, exp_val);
    end
  endtask

  task automatic t_reset_state();
    // R1 and R8: output follows inputs while reset is held
    check("R1", 32'h0000_0000, 5'd0, 32'h0000_0000);
    check("R8", 32'h0000_0420, 5'd7, 32'h4104_0000);
  endtask

  task automatic t_zero();
    check("R1", 32'h0000_0000, 5'd13, 32'h0000_0000);
    check("R1", 32'h0000_0000, 5'd31, 32'h0000_0000);
  endtask

  task automatic t_examples();
    check("R7", 32'h0000_0420, 5'd7, 32'h4104_0000);
    check("R7", 32'h0000_0065, 5'd2, 32'h41CA_0000);
  endtask

  task automatic t_negative();
    check("R2", 32'hFFFF_FBE0, 5'd7, 32'hC104_0000);
    check("R2", 32'hFFFF_FFFF, 5'd0, 32'hBF80_0000);
    check("R2", 32'hFFFF_FF9B, 5'd2, model(32'hFFFF_FF9B, 5'd2));
  endtask

  task automatic t_exponent_sweep();
    // R3: single set bit at each index, several fraction counts
    for (int p = 0; p < 32; p++) begin
      logic [31:0] w;
      w = 32'd1 << p;
      check("R3", w, 5'(p % 32), model(w, 5'(p % 32)));
      check("R3", w, 5'd31 - 5'(p), model(w, 5'd31 - 5'(p)));
    end
  endtask

  task automatic t_fraction_exact();
    // R4: up to 24 significant bits convert exactly
    check("R4", 32'h00FF_FFFF, 5'd0, 32'h4B7F_FFFF);
    check("R4", 32'h0000_0005, 5'd3, 32'h3F20_0000);
    check("R4", 32'h00A5_5A5A, 5'd16, model(32'h00A5_5A5A, 5'd16));
    check("R4", 32'h0000_0003, 5'd1, 32'h3FC0_0000);
  endtask

  task automatic t_truncate();
    check("R5", 32'h7FFF_FFFF, 5'd0, 32'h4EFF_FFFF);
    check("R5", 32'h0100_0001, 5'd0, 32'h4B80_0000);
    check("R5", 32'h1234_5679, 5'd9, model(32'h1234_5679, 5'd9));
  endtask

  task automatic t_most_negative();
    check("R6", 32'h8000_0000, 5'd0, 32'hCF00_0000);
    check("R6", 32'h8000_0000, 5'd31, 32'hBF80_0000);
  endtask

  task automatic t_max_frac();
    check("R9", 32'h0000_0001, 5'd31, 32'h3000_0000);
    check("R9", 32'hFFFF_FFFF, 5'd31, 32'hB000_0000);
  endtask

  initial begin
    t_reset_state();
    @(negedge clk);
    rst = 1'b0;
    t_zero();
    t_examples();
    t_negative();
    t_exponent_sweep();
    t_fraction_exact();
    t_truncate();
    t_most_negative();
    t_max_frac();
    done = 1'b1;
  end

  initial begin
    int n;
    n = 0;
    while (!done && n < 5000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule